// File: doc/BRIEF.md
# Masked Legal-Combination Sweep Generator

This block walks through a 27-bit configuration space and hands out one legal configuration vector per request. A stimulus engine asks for the next vector, applies it elsewhere, and asks again until the generator reports that the space is exhausted. Bits that a runtime mask disables are held at zero and skipped. The counter advances only over the enabled positions: masked positions are forced high before the increment, so the carry passes straight through them, and they are cleared again afterwards.

Some combinations of fields in the vector do not make sense together. A fixed legality filter in logic rejects them. After each request the generator steps internally, one candidate per clock, until it reaches a legal candidate or runs past the top of the space. When a platform lacks a feature, the user sets that feature's control bits (for example the four protection-key bits) in the mask, and the sweep never touches them. The mask is changed only while no sweep is in progress.

Top module: `sweep_gen`

## Requirements
- R1: After reset, `cfg_valid` and `sweep_done` are both low.
- R2: One cycle after `start` is sampled high, `cfg_valid` is high and `cfg_vec` is all zeros. The zero vector is always legal.
- R3: Successive emitted vectors are the enabled-bit patterns in ascending order. Bits set in `dis_mask` are always zero in `cfg_vec`, and the carry skips masked positions.
- R4: A vector with bit 0 (write access) and bit 1 (instruction fetch) both set is never emitted.
- R5: A vector with bit 2 (user-mode access) and bit 3 (supervisor-execute guard enable) both set is never emitted.
- R6: A vector with bit 5 (key read block) or bit 6 (key write block) set while bit 4 (key enable) is clear is never emitted. Bit 7 (key select) is not part of any rule.
- R7: A vector with bit 9 (large-page reserved flag) set while bit 8 (large page) is clear is never emitted.
- R8: While `cfg_valid` is high and no `next_req` or `start` arrives, `cfg_vec` and `cfg_valid` hold their values.
- R9: When no legal candidate remains below 2^27, `sweep_done` rises and `cfg_valid` is low. Both hold, and `next_req` has no effect, until the next `start`.
- R10: `start` restarts the sweep from zero from any state, including mid-sweep and done.
- R11: After a `next_req` is accepted, the outcome (`cfg_valid` or `sweep_done`) appears after s+1 cycles, where s is the number of illegal candidates skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new sweep at the zero vector |
| next_req | input | 1 | Request the next legal vector; accepted only while `cfg_valid` is high |
| dis_mask | input | 27 | Disabled bit positions, held at zero and skipped |
| cfg_vec | output | 27 | Current configuration vector |
| cfg_valid | output | 1 | `cfg_vec` is a legal vector ready for use |
| sweep_done | output | 1 | Sweep exhausted |

## Verification
The assertions assume that `dis_mask` stays unchanged while a sweep is in progress, that is, while a vector is being offered or a search is under way. The bench writes a new mask only right after reset or once `sweep_done` is high, and then it pulses `start`. The bench also assumes `next_req` is a single-cycle pulse issued only while `cfg_valid` is high. It computes every expected vector by scattering a compressed index into the enabled positions, which gives the expected order and skip count independently of the masked-increment arithmetic.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  localparam int CFG_W     = 27;
  localparam int NUM_RULES = 4;

  // field positions decoded by the legality rules
  localparam int B_WR      = 0;
  localparam int B_FETCH   = 1;
  localparam int B_USER    = 2;
  localparam int B_XGUARD  = 3;
  localparam int B_KEY_EN  = 4;
  localparam int B_KEY_RB  = 5;
  localparam int B_KEY_WB  = 6;
  localparam int B_KEY_SEL = 7;
  localparam int B_LGPG    = 8;
  localparam int B_LGRSV   = 9;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_HOLD   = 2'd2,
    ST_DONE   = 2'd3
  } sweep_state_e;

  // one bit per violated rule; all zero means legal
  function automatic logic [NUM_RULES-1:0] rule_hits(input logic [CFG_W-1:0] v);
    logic [NUM_RULES-1:0] h;
    h[0] = v[B_WR] & v[B_FETCH];
    h[1] = v[B_USER] & v[B_XGUARD];
    h[2] = ~v[B_KEY_EN] & (v[B_KEY_RB] | v[B_KEY_WB]);
    h[3] = ~v[B_LGPG] & v[B_LGRSV];
    return h;
  endfunction
endpackage

// File: rtl/sweep_step.sv
module sweep_step #(
  parameter int W = 27
) (
  input  logic [W:0]   cur,
  input  logic [W-1:0] mask,
  output logic [W:0]   nxt,
  output logic         at_end
);
  // force masked bits high, add one, clear them again
  function automatic logic [W:0] masked_bump(input logic [W:0] c, input logic [W-1:0] m);
    logic [W:0] mx;
    mx = {1'b0, m};
    return ((c | mx) + {{W{1'b0}}, 1'b1}) & ~mx;
  endfunction

  always_comb begin
    nxt    = masked_bump(cur, mask);
    at_end = nxt[W];
  end
endmodule

// File: rtl/sweep_legal.sv
module sweep_legal #(
  parameter int W = 27
) (
  input  logic [W-1:0]                    vec,
  output logic [sweep_pkg::NUM_RULES-1:0] viol,
  output logic                            ok
);
  always_comb begin
    viol = sweep_pkg::rule_hits(vec);
    ok   = ~|viol;
  end
endmodule

// File: rtl/sweep_gen.sv
module sweep_gen #(
  parameter int W = sweep_pkg::CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         next_req,
  input  logic [W-1:0] dis_mask,
  output logic [W-1:0] cfg_vec,
  output logic         cfg_valid,
  output logic         sweep_done
);
  import sweep_pkg::*;

  sweep_state_e         state_q;
  logic [W:0]           cand_q;
  logic [W:0]           bump_w;
  logic                 bump_end;
  logic                 bump_ok;
  logic [NUM_RULES-1:0] bump_viol;
  logic                 advance;
  logic                 busy;

  sweep_step #(.W(W)) u_step (
    .cur    (cand_q),
    .mask   (dis_mask),
    .nxt    (bump_w),
    .at_end (bump_end)
  );

  sweep_legal #(.W(W)) u_legal (
    .vec  (bump_w[W-1:0]),
    .viol (bump_viol),
    .ok   (bump_ok)
  );

  assign advance = (state_q == ST_SEARCH) || (state_q == ST_HOLD && next_req);
  assign busy    = (state_q == ST_SEARCH) || (state_q == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cand_q  <= '0;
    end else if (start) begin
      state_q <= ST_HOLD;
      cand_q  <= '0;
    end else if (advance) begin
      if (bump_end) begin
        state_q <= ST_DONE;
      end else begin
        cand_q  <= bump_w;
        state_q <= bump_ok ? ST_HOLD : ST_SEARCH;
      end
    end
  end

  assign cfg_vec    = cand_q[W-1:0];
  assign cfg_valid  = (state_q == ST_HOLD);
  assign sweep_done = (state_q == ST_DONE);

  // R4..R7: an offered vector satisfies every rule
  a_r4_offered_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (rule_hits(cfg_vec) == '0));
  // R3: disabled positions stay zero in an offered vector
  a_r3_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ((cfg_vec & dis_mask) == '0));
  // R3: each accepted step moves strictly upward or ends the sweep
  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && next_req && !start) |=> (sweep_done || (cand_q > $past(cand_q))));
  // R2: start yields the zero vector
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cfg_valid && cfg_vec == '0));
  // R9: done is held and excludes valid
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_done && !start) |=> (sweep_done && !cfg_valid));
  // R8: an offered vector stays put without a request
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !next_req && !start) |=> (cfg_valid && $stable(cfg_vec)));
  // R3: input assumption, mask frozen during a sweep
  a_r3_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(dis_mask));
endmodule

// File: tb/tb_sweep_gen.sv
module tb_sweep_gen;
  localparam int W = sweep_pkg::CFG_W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         next_req = 1'b0;
  logic [W-1:0] dis_mask = '1;
  logic [W-1:0] cfg_vec;
  logic         cfg_valid;
  logic         sweep_done;

  int n_chk = 0;
  int n_bad = 0;

  sweep_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .next_req(next_req),
    .dis_mask(dis_mask), .cfg_vec(cfg_vec), .cfg_valid(cfg_valid),
    .sweep_done(sweep_done)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // place the bits of k, low first, into the enabled positions
  function automatic logic [W-1:0] scatter(input longint k, input logic [W-1:0] m);
    logic [W-1:0] v = '0;
    int j = 0;
    for (int i = 0; i < W; i++) begin
      if (!m[i]) begin
        v[i] = k[j];
        j++;
      end
    end
    return v;
  endfunction

  // legality: R4 wr/fetch, R5 user/guard, R6 key blocks, R7 large-page flag
  function automatic bit ref_legal(input logic [W-1:0] v);
    int bad = 0;
    if (v[0] && v[1]) bad++;
    if (v[2] && v[3]) bad++;
    if ((v[5] || v[6]) && !v[4]) bad++;
    if (v[9] && !v[8]) bad++;
    return bad == 0;
  endfunction

  task automatic run_sweep(input logic [W-1:0] m, input string tag, input int restart_at);
    longint total, k, kk;
    int s, lat, emitted, u, rs;
    logic [W-1:0] held;
    rs = restart_at;
    dis_mask = m;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R2 valid"}, cfg_valid, 1);
    chk({tag, " R2 zero"}, cfg_vec, 0);
    u = 0;
    for (int i = 0; i < W; i++) if (!m[i]) u++;
    total = longint'(1) << u;
    k = 0;
    emitted = 1;
    forever begin
      held = cfg_vec;
      repeat ($urandom_range(2, 0)) begin
        @(negedge clk);
        chk({tag, " R8 hold"}, {cfg_valid, cfg_vec}, {1'b1, held});
      end
      if (emitted == rs) begin
        rs = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R10 restart"}, {cfg_valid, cfg_vec}, {1'b1, {W{1'b0}}});
        k = 0;
        continue;
      end
      kk = k + 1;
      s = 0;
      while (kk < total && !ref_legal(scatter(kk, m))) begin
        kk++;
        s++;
      end
      next_req = 1'b1;
      @(negedge clk);
      next_req = 1'b0;
      lat = 1;
      while (!cfg_valid && !sweep_done && lat < 4000) begin
        @(negedge clk);
        lat++;
      end
      chk({tag, " R11 latency"}, lat, s + 1);
      if (kk == total) begin
        chk({tag, " R9 done"}, {sweep_done, cfg_valid}, 2'b10);
        break;
      end
      chk({tag, " R3 vector"}, {cfg_valid, cfg_vec}, {1'b1, scatter(kk, m)});
      k = kk;
      emitted++;
    end
    repeat (2) begin
      next_req = 1'b1;
      @(negedge clk);
      next_req = 1'b0;
      @(negedge clk);
      chk({tag, " R9 next ignored"}, {sweep_done, cfg_valid}, 2'b10);
    end
  endtask

  function automatic logic [W-1:0] en_bits(input int lo, input int hi);
    logic [W-1:0] m = '1;
    for (int i = lo; i <= hi; i++) m[i] = 1'b0;
    return m;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset", {cfg_valid, sweep_done}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {cfg_valid, sweep_done}, 2'b00);

    run_sweep('1, "all-masked R9", -1);
    run_sweep(en_bits(0, 1), "wr/fetch R4", -1);
    run_sweep(en_bits(2, 3), "user/guard R5", -1);
    run_sweep(en_bits(4, 7), "key R6", -1);
    run_sweep(en_bits(8, 9), "large-page R7", -1);
    run_sweep(en_bits(0, 9), "rules R10", 5);
    m = en_bits(24, 26);
    m[0] = 1'b0;
    m[12] = 1'b0;
    run_sweep(m, "sparse carry R3", -1);
    for (int r = 0; r < 6; r++) begin
      m = '1;
      repeat (7) m[$urandom_range(13, 0)] = 1'b0;
      repeat (2) m[$urandom_range(W - 1, 0)] = 1'b0;
      run_sweep(m, "random R3", (r == 2) ? 3 : -1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule